// File: doc/BRIEF.md
# Multiprocessor Interrupt Enable and Routing Controller

This block gathers level-sensitive interrupt lines from peripherals and hands each one to the processors of a small multiprocessor cluster. Every source has a global enable and a routing vector with one bit per CPU. Every CPU also holds its own mask over all sources. A source reaches a CPU when its line is high, it is globally enabled, its routing bit for that CPU is set, and that CPU has not masked it. Each CPU has one interrupt output. It reads an acknowledge register to learn which source to service, and that read returns the lowest-numbered qualifying source.

Software changes enable and mask state by writing a source number to a dedicated set register or clear register. This avoids read-modify-write of shared bit vectors. The register bus has two windows. The global window holds the control word, the enable set and clear registers, and one routing word per source. The per-CPU window holds the acknowledge register and the mask set and clear registers. The `bus_cpu` input selects which CPU's per-CPU window is accessed.

Identifier 0 is reserved for the inter-processor doorbell path, which this block does not implement, so source 0 never reports. One source number is a private per-CPU timer. It has one input line per CPU and is gated only by that CPU's mask. The bus has no back-pressure: a write takes effect at the clock edge where `bus_wr` is sampled high, and read data is presented with `bus_rvalid` exactly one cycle after `bus_rd`.

Top module: `mpic_irq_router`

## Requirements
- R1: After reset all global enables are clear, every CPU masks every source, all routing vectors are zero, every `irq_o` bit is low, and every acknowledge read returns 1023.
- R2: A write of source number n (1 ≤ n < NSRC, upper data bits zero) to global offset 0x30 sets n's global enable, and a write to global offset 0x34 clears it. A write of 0 or of an out-of-range number changes nothing.
- R3: The routing word of source n is at global offset 0x100 + 4n. Bits [NCPU-1:0] hold one bit per CPU, and reads return the written value. One source may be routed to several CPUs, and each of them then sees it.
- R4: A read of global offset 0x00 returns NSRC in bits [11:2], with all other bits zero.
- R5: A write of source number n to per-CPU offset 0x48 masks n for the CPU chosen by `bus_cpu`, and a write to per-CPU offset 0x4C unmasks it. The masks of the other CPUs do not change.
- R6: A read of per-CPU offset 0x44 returns, in bits [9:0], the lowest-numbered source qualifying for the selected CPU, or 1023 when none qualifies. Bits [31:10] are zero.
- R7: Source 0 never qualifies, and the `src_lvl[0]` line is ignored. Source TIMER_SRC (default 5) qualifies for CPU c when `tmr_lvl[c]` is high and c has it unmasked; its global enable, its routing word and `src_lvl[TIMER_SRC]` are ignored.
- R8: `irq_o[c]` is high in exactly the cycles in which an acknowledge read by CPU c would return a value other than 1023. It follows the input levels with no storage.
- R9: `bus_rvalid` pulses in the cycle after `bus_rd`. Reads of unmapped offsets, and of the set and clear registers, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cpu | input | CW | CPU whose per-CPU window is accessed |
| bus_win | input | 1 | 0 selects the global window, 1 selects the per-CPU window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte offset within the window |
| bus_wdata | input | 32 | Write data (a source number or a routing word) |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| src_lvl | input | NSRC | Level interrupt lines of the shared sources |
| tmr_lvl | input | NCPU | Private timer line of each CPU |
| irq_o | output | NCPU | Interrupt request to each CPU |

## Verification
A wrong enable, mask or routing bit shows up at once on `irq_o` and on the acknowledge value of the next read. Both are combinational on the stored state, so a corrupted bit is visible within one cycle of a read. Because the acknowledge value is a priority choice, a stuck bit can hide behind a lower-numbered source. For that reason the stimulus masks or disables the lower source and reads again, so the higher source becomes the answer. Per-CPU isolation is checked by reading the acknowledge register of both CPUs after every mask change.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
  localparam int IDW = 10;
  localparam logic [IDW-1:0] ID_NONE = 10'd1023;

  localparam int OFF_CTRL    = 'h000;
  localparam int OFF_EN_SET  = 'h030;
  localparam int OFF_EN_CLR  = 'h034;
  localparam int OFF_ACK     = 'h044;
  localparam int OFF_MSK_SET = 'h048;
  localparam int OFF_MSK_CLR = 'h04C;
  localparam int OFF_ROUTE   = 'h100;

  typedef enum logic {
    WIN_GLOBAL = 1'b0,
    WIN_CPU    = 1'b1
  } win_e;
endpackage

// File: rtl/mpic_pick.sv
module mpic_pick
  import mpic_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0]   req,
  output logic [IDW-1:0] id_o
);
  // lowest set bit wins; bit 0 is reserved and skipped
  always_comb begin
    id_o = ID_NONE;
    for (int i = N - 1; i >= 1; i--) begin
      if (req[i]) id_o = IDW'(i);
    end
  end
endmodule

// File: rtl/mpic_cpu_slice.sv
module mpic_cpu_slice
  import mpic_pkg::*;
#(
  parameter int NSRC      = 32,
  parameter int TIMER_SRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msk_set,
  input  logic            msk_clr,
  input  logic [IDW-1:0]  sel_i,
  input  logic [NSRC-1:0] lvl_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] rte_i,
  input  logic            tmr_i,
  output logic [IDW-1:0]  id_o,
  output logic            irq_o
);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] pend;
  logic            sel_ok;
  logic [SW-1:0]   sel_s;

  assign sel_ok = (int'(sel_i) < NSRC);
  assign sel_s  = sel_i[SW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (msk_set && sel_ok) begin
      mask_q[sel_s] <= 1'b1;
    end else if (msk_clr && sel_ok) begin
      mask_q[sel_s] <= 1'b0;
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    if (s == 0) begin : g_rsv
      assign pend[s] = 1'b0;
    end else if (s == TIMER_SRC) begin : g_tmr
      assign pend[s] = tmr_i & ~mask_q[s];
    end else begin : g_shared
      assign pend[s] = lvl_i[s] & en_i[s] & rte_i[s] & ~mask_q[s];
    end
  end

  assign irq_o = |pend;

  mpic_pick #(.N(NSRC)) u_pick (
    .req  (pend),
    .id_o (id_o)
  );

  p_irq_matches_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (id_o != ID_NONE));

  p_id_never_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    id_o != '0);

  p_id_is_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_o != ID_NONE) |->
      ((pend & ((NSRC'(1) << id_o) - NSRC'(1))) == '0) && pend[id_o[SW-1:0]]);

  p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_set && sel_ok) |=> mask_q[$past(sel_s)]);

  p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_clr && !msk_set && sel_ok) |=> !mask_q[$past(sel_s)]);
endmodule

// File: rtl/mpic_irq_router.sv
module mpic_irq_router
  import mpic_pkg::*;
#(
  parameter int NCPU      = 2,
  parameter int NSRC      = 32,
  parameter int TIMER_SRC = 5,
  parameter int AW        = 12,
  localparam int CW       = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   bus_cpu,
  input  logic            bus_win,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            bus_rvalid,
  input  logic [NSRC-1:0] src_lvl,
  input  logic [NCPU-1:0] tmr_lvl,
  output logic [NCPU-1:0] irq_o
);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] en_q;
  logic [NCPU-1:0] route_q [NSRC];
  logic [NSRC-1:0] rte_c   [NCPU];
  logic [IDW-1:0]  id_c    [NCPU];

  logic          glb, pcu, wd_small, num_ok, in_route;
  logic [AW-1:0] roff;
  logic [SW-1:0] ridx, wnum;
  logic [31:0]   rd_mux;

  assign glb      = (bus_win == WIN_GLOBAL);
  assign pcu      = (bus_win == WIN_CPU);
  assign wd_small = (bus_wdata[31:IDW] == '0);
  assign num_ok   = wd_small && (int'(bus_wdata[IDW-1:0]) < NSRC) && (bus_wdata != 0);
  assign wnum     = bus_wdata[SW-1:0];
  assign roff     = bus_addr - AW'(OFF_ROUTE);
  assign ridx     = roff[SW+1:2];
  assign in_route = (int'(bus_addr) >= OFF_ROUTE) &&
                    (int'(bus_addr) < OFF_ROUTE + 4 * NSRC) &&
                    (bus_addr[1:0] == 2'b00);

  // global enable: set/clear by source number
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (bus_wr && glb && num_ok) begin
      if (int'(bus_addr) == OFF_EN_SET)      en_q[wnum] <= 1'b1;
      else if (int'(bus_addr) == OFF_EN_CLR) en_q[wnum] <= 1'b0;
    end
  end

  // routing words, one per source
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSRC; s++) route_q[s] <= '0;
    end else if (bus_wr && glb && in_route) begin
      route_q[ridx] <= bus_wdata[NCPU-1:0];
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    for (genvar s = 0; s < NSRC; s++) begin : g_rt
      assign rte_c[c][s] = route_q[s][c];
    end

    logic sel_me;
    assign sel_me = bus_wr && pcu && wd_small && (int'(bus_cpu) == c);

    mpic_cpu_slice #(.NSRC(NSRC), .TIMER_SRC(TIMER_SRC)) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .msk_set (sel_me && (int'(bus_addr) == OFF_MSK_SET)),
      .msk_clr (sel_me && (int'(bus_addr) == OFF_MSK_CLR)),
      .sel_i   (bus_wdata[IDW-1:0]),
      .lvl_i   (src_lvl),
      .en_i    (en_q),
      .rte_i   (rte_c[c]),
      .tmr_i   (tmr_lvl[c]),
      .id_o    (id_c[c]),
      .irq_o   (irq_o[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (glb) begin
      if (int'(bus_addr) == OFF_CTRL) rd_mux = 32'(NSRC) << 2;
      else if (in_route)              rd_mux = 32'(route_q[ridx]);
    end else if (int'(bus_addr) == OFF_ACK && int'(bus_cpu) < NCPU) begin
      rd_mux = 32'(id_c[bus_cpu]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  p_rvalid_follows_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && glb && num_ok && int'(bus_addr) == OFF_EN_SET) |=> en_q[$past(wnum)]);

  p_en_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && glb && num_ok && int'(bus_addr) == OFF_EN_CLR) |=> !en_q[$past(wnum)]);

  p_route_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && glb && in_route) |=> route_q[$past(ridx)] == $past(bus_wdata[NCPU-1:0]));
endmodule

// File: tb/tb_mpic_irq_router.sv
module tb_mpic_irq_router;
  localparam int NCPU = 2;
  localparam int NSRC = 32;
  localparam int AW   = 12;
  localparam logic [31:0] NONE = 32'd1023;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [0:0]      bus_cpu = '0;
  logic            bus_win = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            bus_rvalid;
  logic [NSRC-1:0] src_lvl = '0;
  logic [NCPU-1:0] tmr_lvl = '0;
  logic [NCPU-1:0] irq_o;

  int vecs = 0, errs = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  mpic_irq_router #(.NCPU(NCPU), .NSRC(NSRC), .TIMER_SRC(5), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_win(bus_win),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .src_lvl(src_lvl), .tmr_lvl(tmr_lvl), .irq_o(irq_o)
  );

  task automatic wr(input int cpu, input bit win, input int addr, input int data);
    @(negedge clk);
    bus_cpu = 1'(cpu); bus_win = win; bus_addr = AW'(addr);
    bus_wdata = 32'(data); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: push expectation, then issue the read
  task automatic rd(input int cpu, input bit win, input int addr,
                    input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_cpu = 1'(cpu); bus_win = win; bus_addr = AW'(addr); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic [NCPU-1:0] exp, input string tag);
    @(negedge clk);
    vecs++;
    if (irq_o !== exp) begin
      errs++;
      $display("FAIL %s: irq_o got %b expected %b", tag, irq_o, exp);
    end
  endtask

  // monitor: compare read data as it appears
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      vecs++;
      if (exp_q.size() == 0) begin
        errs++;
        $display("FAIL R9: unexpected rvalid, data %0h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errs++;
          $display("FAIL %s: rdata got %0h expected %0h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(2'b00, "R1");
    rd(0, 1, 'h44, NONE, "R1");
    rd(1, 1, 'h44, NONE, "R1");
    // R4 control word
    rd(0, 0, 'h00, 32'd128, "R4");
    // source 7 towards cpu0
    src_lvl[7] = 1'b1;
    wr(0, 0, 'h30, 7);
    wr(0, 1, 'h4C, 7);
    rd(0, 1, 'h44, NONE, "R3 unrouted");
    wr(0, 0, 'h100 + 4 * 7, 1);
    rd(0, 0, 'h100 + 4 * 7, 32'd1, "R3 readback");
    rd(0, 1, 'h44, 32'd7, "R6");
    rd(1, 1, 'h44, NONE, "R6 cpu1");
    chk_irq(2'b01, "R8");
    // source 3 routed to both cpus
    src_lvl[3] = 1'b1;
    wr(0, 0, 'h30, 3);
    wr(0, 0, 'h100 + 4 * 3, 3);
    wr(0, 1, 'h4C, 3);
    wr(1, 1, 'h4C, 3);
    rd(0, 1, 'h44, 32'd3, "R6 lowest");
    rd(1, 1, 'h44, 32'd3, "R3 multi-route");
    // R5 mask on cpu0 only
    wr(0, 1, 'h48, 3);
    rd(0, 1, 'h44, 32'd7, "R5 masked");
    rd(1, 1, 'h44, 32'd3, "R5 other cpu");
    // R2 clear enable
    wr(0, 0, 'h34, 3);
    rd(1, 1, 'h44, NONE, "R2 clear");
    chk_irq(2'b01, "R2");
    // R2 out-of-range and zero writes ignored
    wr(0, 0, 'h34, 7 + 1024);
    wr(0, 0, 'h34, 40);
    rd(0, 1, 'h44, 32'd7, "R2 ignored");
    // R7 source 0 ignored
    src_lvl[0] = 1'b1;
    wr(0, 0, 'h30, 0);
    wr(0, 0, 'h100, 1);
    wr(0, 1, 'h4C, 0);
    rd(0, 1, 'h44, 32'd7, "R7 src0");
    // R7 private timer on cpu1, no enable, no route
    src_lvl[5] = 1'b1;
    tmr_lvl[1] = 1'b1;
    wr(1, 1, 'h4C, 5);
    rd(1, 1, 'h44, 32'd5, "R7 timer");
    rd(0, 1, 'h44, 32'd7, "R7 timer cpu0");
    chk_irq(2'b11, "R7");
    tmr_lvl[1] = 1'b0;
    chk_irq(2'b01, "R8 level");
    rd(1, 1, 'h44, NONE, "R8 level");
    // R8 source drop
    src_lvl[7] = 1'b0;
    chk_irq(2'b00, "R8 drop");
    rd(0, 1, 'h44, NONE, "R6 none");
    // R9 unmapped and write-only reads
    rd(0, 0, 'h200, 32'd0, "R9 unmapped");
    rd(0, 0, 'h30, 32'd0, "R9 set reg");
    repeat (4) @(negedge clk);
    vecs++;
    if (exp_q.size() != 0) begin
      errs++;
      $display("FAIL R9: pending reads got %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule